// File: doc/BRIEF.md
# Camera Pixel Packer

The packer sits at the end of a camera capture path. It takes one pixel per transfer and packs it into 32-bit memory words. Each pixel carries three 8-bit components: a luma channel (G for RGB, Y for YUV), a first chroma channel (B or U) and a second chroma channel (R or V). Two sideband marks travel with each pixel: start of frame on the first pixel of a frame, and end of line on the last pixel of each line.

A 4-bit format code selects the memory layout. The packed layouts are 24-bit, 16-bit 5-6-5, two 32-bit layouts with an inserted alpha byte, 8-bit monochrome, 32-bit alpha-YUV, and two 4:2:2 byte orders. A swap bit exchanges the two chroma channels. Format and swap are taken from the configuration inputs only on the start-of-frame pixel and are held for the rest of the frame.

Words leave in little-endian order: the first byte in memory sits in bits 7:0. Both the pixel input and the word output use valid/ready handshakes. Any code outside the supported set raises an error flag. Pixels of that frame are then consumed and dropped.

Top module: `pixel_packer`

## Requirements
- R1: After reset, out_valid and fmt_err are 0 and in_ready is 1, and the active format is code 0 with no swap.
- R2: Code 0 writes 3 bytes per pixel in memory order chroma1, luma, chroma2, so 4 pixels fill 3 words.
- R3: Code 1 writes 2 bytes per pixel holding the 16-bit value {chroma2[7:3], luma[7:2], chroma1[7:3]}, low byte first.
- R4: Code 2 writes bytes chroma1, luma, chroma2, 0xFF. Code 3 writes bytes 0xFF, chroma1, luma, chroma2. Every word of these frames carries the 0xFF alpha byte.
- R5: Code 4 writes only the luma byte of each pixel, 4 pixels per word.
- R6: Code 5 writes bytes chroma2, chroma1, luma, 0xFF per pixel.
- R7: Codes 6 and 10 emit one word per pixel pair. Code 6 writes Y0, U0, Y1, V1 and code 10 writes U0, Y0, V1, Y1. U comes from the even pixel's chroma1 and V from the odd pixel's chroma2.
- R8: In codes 6 and 10, a line with an odd pixel count completes its last pair by using the last pixel for both halves.
- R9: With the swap bit at 1, chroma1 and chroma2 trade places in every layout. With it at 0, no change occurs.
- R10: At end of line, a partly filled word is emitted with its unused upper bytes at zero. out_eol is 1 exactly on the last word of each line.
- R11: Codes 7, 8, 9 and 11 to 15 set fmt_err for that frame. No word is emitted, and every pixel is still accepted.
- R12: cfg_fmt and cfg_swap matter only on a pixel with in_sof at 1. Changes at any other time do not affect packing.
- R13: While out_valid is 1 and out_ready is 0, out_data and out_eol hold and in_ready is 0. No word is lost or duplicated under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fmt | input | 4 | Format code, taken on start-of-frame pixel |
| cfg_swap | input | 1 | Chroma swap, taken on start-of-frame pixel |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel accepted when high with in_valid |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eol | input | 1 | Pixel is the last of a line |
| in_lum | input | 8 | Luma channel (G or Y) |
| in_ca | input | 8 | First chroma channel (B or U) |
| in_cb | input | 8 | Second chroma channel (R or V) |
| out_valid | output | 1 | Word present |
| out_ready | input | 1 | Word taken when high with out_valid |
| out_data | output | 32 | Packed word, first memory byte in bits 7:0 |
| out_eol | output | 1 | Word is the last of its line |
| fmt_err | output | 1 | Current frame uses an unsupported code |

## Verification
The assertions check four things on every cycle: the output word stays stable under back-pressure, no pixel is taken while a word is stalled, nothing is emitted during an unsupported frame, and the alpha byte sits in the right lane for the three alpha layouts. Only the bench scenarios can show the byte order and bit fields of each layout, 4:2:2 pairing with odd-length padding, zero-padded flushes at line end, and the rule that configuration is taken only at frame start. The bench covers these by comparing every word against a byte-level model while the configuration inputs carry junk between frame starts.

// File: rtl/pixel_packer_pkg.sv
package pixel_packer_pkg;

    localparam int unsigned COMP_W     = 8;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned WORD_W     = WORD_BYTES * COMP_W;
    localparam int unsigned ACC_BYTES  = WORD_BYTES - 1;
    localparam int unsigned ACC_W      = ACC_BYTES * COMP_W;
    localparam int unsigned CMB_BYTES  = ACC_BYTES + WORD_BYTES;
    localparam int unsigned CNT_W      = $clog2(WORD_BYTES);
    localparam int unsigned NB_W       = $clog2(WORD_BYTES + 1);

    typedef logic [3:0] fmt_t;

    localparam fmt_t FMT_PACK24 = 4'd0;
    localparam fmt_t FMT_P565   = 4'd1;
    localparam fmt_t FMT_APRE   = 4'd2;
    localparam fmt_t FMT_APOST  = 4'd3;
    localparam fmt_t FMT_LUMA8  = 4'd4;
    localparam fmt_t FMT_AYUV   = 4'd5;
    localparam fmt_t FMT_Y_FST  = 4'd6;
    localparam fmt_t FMT_C_FST  = 4'd10;

    localparam logic [COMP_W-1:0] ALPHA_OPAQUE = '1;

    function automatic logic fmt_ok(fmt_t f);
        return (f <= FMT_Y_FST) || (f == FMT_C_FST);
    endfunction

    function automatic logic fmt_is_pair(fmt_t f);
        return (f == FMT_Y_FST) || (f == FMT_C_FST);
    endfunction

endpackage

// File: rtl/pp_cfg_latch.sv
module pp_cfg_latch
    import pixel_packer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sof_now,
    input  logic take,
    input  fmt_t cfg_fmt,
    input  logic cfg_swap,
    output fmt_t eff_fmt,
    output logic eff_swap,
    output logic eff_bad,
    output logic err_flag
);

    typedef struct packed {
        fmt_t fmt;
        logic swap;
        logic bad;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (take) begin
            cfg_d.fmt  = cfg_fmt;
            cfg_d.swap = cfg_swap;
            cfg_d.bad  = !fmt_ok(cfg_fmt);
        end
        if (sof_now) begin
            eff_fmt  = cfg_fmt;
            eff_swap = cfg_swap;
            eff_bad  = !fmt_ok(cfg_fmt);
        end else begin
            eff_fmt  = cfg_q.fmt;
            eff_swap = cfg_q.swap;
            eff_bad  = cfg_q.bad;
        end
        err_flag = cfg_q.bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

endmodule

// File: rtl/pp_pixel_map.sv
module pp_pixel_map
    import pixel_packer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              sof,
    input  logic              eol,
    input  fmt_t              fmt,
    input  logic              swap,
    input  logic              bad,
    input  logic [COMP_W-1:0] lum,
    input  logic [COMP_W-1:0] ca,
    input  logic [COMP_W-1:0] cb,
    output logic [WORD_W-1:0] bytes_out,
    output logic [NB_W-1:0]   nbytes
);

    typedef struct packed {
        logic              held;
        logic [COMP_W-1:0] y0;
        logic [COMP_W-1:0] u0;
    } pair_t;

    pair_t pr_d, pr_q;

    logic [COMP_W-1:0] c1, c2;
    logic [COMP_W-1:0] py0, pu0, py1, pv1;
    logic              have_even;
    logic              pair_out;

    always_comb begin
        c1        = swap ? cb : ca;
        c2        = swap ? ca : cb;
        have_even = pr_q.held && !sof;
        pr_d      = pr_q;
        bytes_out = '0;
        nbytes    = '0;
        pair_out  = 1'b0;
        py0       = have_even ? pr_q.y0 : lum;
        pu0       = have_even ? pr_q.u0 : c1;
        py1       = lum;
        pv1       = c2;

        if (!bad) begin
            case (fmt)
                FMT_PACK24: begin
                    bytes_out = {{COMP_W{1'b0}}, c2, lum, c1};
                    nbytes    = NB_W'(3);
                end
                FMT_P565: begin
                    bytes_out = {{(2*COMP_W){1'b0}}, c2[7:3], lum[7:2], c1[7:3]};
                    nbytes    = NB_W'(2);
                end
                FMT_APRE: begin
                    bytes_out = {ALPHA_OPAQUE, c2, lum, c1};
                    nbytes    = NB_W'(4);
                end
                FMT_APOST: begin
                    bytes_out = {c2, lum, c1, ALPHA_OPAQUE};
                    nbytes    = NB_W'(4);
                end
                FMT_LUMA8: begin
                    bytes_out = {{(3*COMP_W){1'b0}}, lum};
                    nbytes    = NB_W'(1);
                end
                FMT_AYUV: begin
                    bytes_out = {ALPHA_OPAQUE, lum, c1, c2};
                    nbytes    = NB_W'(4);
                end
                FMT_Y_FST, FMT_C_FST: begin
                    pair_out = have_even || eol;
                    if (pair_out) begin
                        nbytes = NB_W'(4);
                        if (fmt == FMT_Y_FST) bytes_out = {pv1, py1, pu0, py0};
                        else                  bytes_out = {py1, pv1, py0, pu0};
                    end
                end
                default: begin
                    nbytes = '0;
                end
            endcase
        end

        if (push) begin
            pr_d.held = fmt_is_pair(fmt) && !bad && !have_even && !eol;
            pr_d.y0   = lum;
            pr_d.u0   = c1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end

endmodule

// File: rtl/pp_word_pack.sv
module pp_word_pack
    import pixel_packer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              eol,
    input  logic [WORD_W-1:0] bytes_in,
    input  logic [NB_W-1:0]   nbytes,
    output logic              can_accept,
    output logic [WORD_W-1:0] word,
    output logic              word_vld,
    input  logic              word_rdy,
    output logic              word_eol
);

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [CNT_W-1:0]  cnt;
        logic              flush;
        logic [WORD_W-1:0] word;
        logic              vld;
        logic              eol;
    } pk_t;

    pk_t pk_d, pk_q;

    logic [COMP_W-1:0]           src [WORD_BYTES];
    logic [COMP_W-1:0]           cmb [CMB_BYTES];
    logic [CMB_BYTES*COMP_W-1:0] accx;
    logic [NB_W-1:0]             total;
    logic [NB_W-1:0]             k;
    logic [WORD_W-1:0]           w4;
    logic [ACC_W-1:0]            left;
    logic [ACC_W-1:0]            low3;
    logic                        slot_free;

    always_comb begin
        pk_d      = pk_q;
        slot_free = !pk_q.vld || word_rdy;
        accx      = {{(WORD_BYTES*COMP_W){1'b0}}, pk_q.acc};
        total     = NB_W'(pk_q.cnt) + nbytes;

        for (int i = 0; i < WORD_BYTES; i++) begin
            src[i] = bytes_in[i*COMP_W +: COMP_W];
        end

        for (int i = 0; i < CMB_BYTES; i++) begin
            k = NB_W'(i) - NB_W'(pk_q.cnt);
            if (i < int'(pk_q.cnt))   cmb[i] = accx[i*COMP_W +: COMP_W];
            else if (k < nbytes)      cmb[i] = src[k[CNT_W-1:0]];
            else                      cmb[i] = '0;
        end

        for (int i = 0; i < WORD_BYTES; i++) begin
            w4[i*COMP_W +: COMP_W] = cmb[i];
        end
        for (int i = 0; i < ACC_BYTES; i++) begin
            left[i*COMP_W +: COMP_W] = cmb[i + WORD_BYTES];
            low3[i*COMP_W +: COMP_W] = cmb[i];
        end

        if (pk_q.vld && word_rdy) pk_d.vld = 1'b0;

        if (pk_q.flush) begin
            if (slot_free) begin
                pk_d.word  = {{COMP_W{1'b0}}, pk_q.acc};
                pk_d.vld   = 1'b1;
                pk_d.eol   = 1'b1;
                pk_d.acc   = '0;
                pk_d.cnt   = '0;
                pk_d.flush = 1'b0;
            end
        end else if (push) begin
            if (total >= NB_W'(WORD_BYTES)) begin
                pk_d.word = w4;
                pk_d.vld  = 1'b1;
                pk_d.acc  = left;
                pk_d.cnt  = CNT_W'(total - NB_W'(WORD_BYTES));
                if (eol && (total != NB_W'(WORD_BYTES))) begin
                    pk_d.flush = 1'b1;
                    pk_d.eol   = 1'b0;
                end else begin
                    pk_d.eol   = eol;
                end
            end else if (eol) begin
                if (total != '0) begin
                    pk_d.word = w4;
                    pk_d.vld  = 1'b1;
                    pk_d.eol  = 1'b1;
                end
                pk_d.acc = '0;
                pk_d.cnt = '0;
            end else begin
                pk_d.acc = low3;
                pk_d.cnt = total[CNT_W-1:0];
            end
        end

        can_accept = !pk_q.flush && slot_free;
        word       = pk_q.word;
        word_vld   = pk_q.vld;
        word_eol   = pk_q.eol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

endmodule

// File: rtl/pixel_packer.sv
module pixel_packer
    import pixel_packer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cfg_fmt,
    input  logic              cfg_swap,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sof,
    input  logic              in_eol,
    input  logic [COMP_W-1:0] in_lum,
    input  logic [COMP_W-1:0] in_ca,
    input  logic [COMP_W-1:0] in_cb,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_eol,
    output logic              fmt_err
);

    fmt_t              eff_fmt;
    logic              eff_swap;
    logic              eff_bad;
    logic              can_accept;
    logic              accept;
    logic [WORD_W-1:0] px_bytes;
    logic [NB_W-1:0]   px_n;

    assign in_ready = can_accept;
    assign accept   = in_valid && can_accept;

    pp_cfg_latch u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof_now  (in_valid && in_sof),
        .take     (accept && in_sof),
        .cfg_fmt  (cfg_fmt),
        .cfg_swap (cfg_swap),
        .eff_fmt  (eff_fmt),
        .eff_swap (eff_swap),
        .eff_bad  (eff_bad),
        .err_flag (fmt_err)
    );

    pp_pixel_map u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .sof       (in_sof),
        .eol       (in_eol),
        .fmt       (eff_fmt),
        .swap      (eff_swap),
        .bad       (eff_bad),
        .lum       (in_lum),
        .ca        (in_ca),
        .cb        (in_cb),
        .bytes_out (px_bytes),
        .nbytes    (px_n)
    );

    pp_word_pack u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (accept),
        .eol        (in_eol),
        .bytes_in   (px_bytes),
        .nbytes     (px_n),
        .can_accept (can_accept),
        .word       (out_data),
        .word_vld   (out_valid),
        .word_rdy   (out_ready),
        .word_eol   (out_eol)
    );

endmodule

// File: rtl/pixel_packer_chk.sv
module pixel_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  cfg_fmt,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_sof,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_eol,
    input logic        fmt_err
);

    logic [3:0] trk_fmt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            trk_fmt <= 4'd0;
        else if (in_valid && in_ready && in_sof) trk_fmt <= cfg_fmt;
    end

    p_hold_word_r13: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eol));

    p_no_take_stalled_r13: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    p_err_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> !out_valid);

    p_alpha_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (trk_fmt == 4'd2) |-> out_data[31:24] == 8'hFF);

    p_alpha_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (trk_fmt == 4'd3) |-> out_data[7:0] == 8'hFF);

    p_ayuv_alpha_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (trk_fmt == 4'd5) |-> out_data[31:24] == 8'hFF);

endmodule

bind pixel_packer pixel_packer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_fmt   (cfg_fmt),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_eol   (out_eol),
    .fmt_err   (fmt_err)
);

// File: tb/pixel_packer_bench.sv
module pixel_packer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_fmt = '0;
    logic        cfg_swap = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sof = 1'b0;
    logic        in_eol = 1'b0;
    logic [7:0]  in_lum = '0, in_ca = '0, in_cb = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_eol;
    logic        fmt_err;

    always #5 clk = ~clk;

    pixel_packer u_pixel_packer (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_swap(cfg_swap),
        .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_eol(in_eol),
        .in_lum(in_lum), .in_ca(in_ca), .in_cb(in_cb),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_eol(out_eol), .fmt_err(fmt_err)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;
    bit          rnd_ready = 0;
    bit          err_frame = 0;
    string       cur_req = "R1";
    logic [32:0] expq[$];
    logic [7:0]  pl[16], pa[16], pb[16];
    logic [3:0]  frm_fmt = 4'd0;
    bit          frm_swap = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Byte-level model of one line
    task automatic model_line(input logic [3:0] f, input bit sw, input int n);
        logic [7:0] bq[$];
        logic [7:0] a, b, p, y0, u0, y1, v1;
        logic [15:0] v16;
        logic [31:0] w;
        y0 = 0; u0 = 0;
        for (int i = 0; i < n; i++) begin
            a = sw ? pb[i] : pa[i];
            b = sw ? pa[i] : pb[i];
            p = pl[i];
            case (f)
                4'd0: begin bq.push_back(a); bq.push_back(p); bq.push_back(b); end
                4'd1: begin
                    v16 = {b[7:3], p[7:2], a[7:3]};
                    bq.push_back(v16[7:0]); bq.push_back(v16[15:8]);
                end
                4'd2: begin bq.push_back(a); bq.push_back(p); bq.push_back(b); bq.push_back(8'hFF); end
                4'd3: begin bq.push_back(8'hFF); bq.push_back(a); bq.push_back(p); bq.push_back(b); end
                4'd4: bq.push_back(p);
                4'd5: begin bq.push_back(b); bq.push_back(a); bq.push_back(p); bq.push_back(8'hFF); end
                default: begin
                    if (i % 2 == 0) begin
                        y0 = p; u0 = a;
                    end
                    if (i % 2 == 1 || i == n - 1) begin
                        y1 = p; v1 = b;
                        if (f == 4'd6) begin
                            bq.push_back(y0); bq.push_back(u0); bq.push_back(y1); bq.push_back(v1);
                        end else begin
                            bq.push_back(u0); bq.push_back(y0); bq.push_back(v1); bq.push_back(y1);
                        end
                    end
                end
            endcase
        end
        while (bq.size() > 0) begin
            w = '0;
            for (int k2 = 0; k2 < 4; k2++) begin
                if (bq.size() > 0) w[k2*8 +: 8] = bq.pop_front();
            end
            expq.push_back({(bq.size() == 0), w});
        end
    endtask

    task automatic send_line(input logic [3:0] f, input bit sw, input bit sof,
                             input int n, input bit model);
        for (int i = 0; i < n; i++) begin
            pl[i] = 8'($urandom); pa[i] = 8'($urandom); pb[i] = 8'($urandom);
        end
        if (sof) begin frm_fmt = f; frm_swap = sw; end
        if (model) model_line(frm_fmt, frm_swap, n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_lum = pl[i]; in_ca = pa[i]; in_cb = pb[i];
            in_sof = sof && (i == 0);
            in_eol = (i == n - 1);
            if (in_sof) begin cfg_fmt = f; cfg_swap = sw; end
            else begin cfg_fmt = 4'($urandom); cfg_swap = 1'($urandom); end
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        cfg_fmt = 4'($urandom); cfg_swap = 1'($urandom);
    endtask

    task automatic drain();
        while (expq.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic frame(input logic [3:0] f, input bit sw, input int lines, input int len);
        for (int l = 0; l < lines; l++) send_line(f, sw, l == 0, len, 1);
        drain();
    endtask

    // Output ready driver
    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
        end
    end

    // Word monitor
    initial begin
        logic [32:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid && out_ready) begin
                if (err_frame) begin
                    chk(0, "R11", "word during unsupported frame", {31'b0, out_eol, out_data}, 0);
                end else if (expq.size() == 0) begin
                    chk(0, cur_req, "unexpected word", {31'b0, out_eol, out_data}, 0);
                end else begin
                    e = expq.pop_front();
                    chk({out_eol, out_data} === e, cur_req, "word/eol",
                        {31'b0, out_eol, out_data}, {31'b0, e});
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired req=%s actual=hung expected=done", cur_req);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
        chk(fmt_err == 0, "R1", "fmt_err in reset", fmt_err, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
        chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
        @(posedge clk); #1;

        cur_req = "R2";  frame(4'd0, 0, 2, 4); frame(4'd0, 0, 1, 5);
        cur_req = "R3";  frame(4'd1, 0, 2, 3); frame(4'd1, 0, 1, 4);
        cur_req = "R4";  frame(4'd2, 0, 1, 3); frame(4'd3, 0, 1, 3);
        cur_req = "R5";  frame(4'd4, 0, 1, 8); frame(4'd4, 0, 1, 1);
        cur_req = "R6";  frame(4'd5, 0, 2, 2);
        cur_req = "R7";  frame(4'd6, 0, 1, 6); frame(4'd10, 0, 1, 4);
        cur_req = "R8";  frame(4'd6, 0, 2, 5); frame(4'd10, 0, 1, 1); frame(4'd10, 0, 1, 3);
        cur_req = "R9";
        for (int f = 0; f <= 6; f++) frame(4'(f), 1, 1, 4);
        frame(4'd10, 1, 1, 3);
        cur_req = "R10"; frame(4'd0, 0, 1, 7); frame(4'd4, 0, 1, 3); frame(4'd1, 0, 1, 1);

        cur_req = "R11";
        err_frame = 1;
        send_line(4'd8, 0, 1, 5, 0);
        send_line(4'd8, 0, 0, 3, 0);
        @(negedge clk);
        chk(fmt_err == 1, "R11", "fmt_err after bad code", fmt_err, 1);
        chk(in_ready == 1, "R11", "pixels still consumed", in_ready, 1);
        @(posedge clk); #1;
        send_line(4'd13, 0, 1, 4, 0);
        @(negedge clk);
        chk(fmt_err == 1, "R11", "fmt_err code 13", fmt_err, 1);
        @(posedge clk); #1;
        err_frame = 0;
        frame(4'd4, 0, 1, 4);
        @(negedge clk);
        chk(fmt_err == 0, "R11", "fmt_err cleared by good frame", fmt_err, 0);
        @(posedge clk); #1;

        cur_req = "R12";
        send_line(4'd4, 0, 1, 4, 1);
        cfg_fmt = 4'd0; cfg_swap = 1;
        send_line(4'd0, 1, 0, 4, 1);
        drain();

        cur_req = "R13";
        rnd_ready = 1;
        frame(4'd0, 0, 2, 9); frame(4'd6, 1, 2, 7); frame(4'd4, 0, 2, 6);

        cur_req = "R12";
        for (int fr = 0; fr < 40; fr++) begin
            int pick;
            logic [3:0] f;
            pick = $urandom % 8;
            f = (pick == 7) ? 4'd10 : 4'(pick);
            frame(f, 1'($urandom), 1 + $urandom % 3, 1 + $urandom % 12);
        end
        rnd_ready = 0;
        drain();

        chk(expq.size() == 0, "R10", "expected words left", expq.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule